// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block turns a flat 64 KB CPU address space into a window over a larger physical store. The space is cut into four 16 KB slots. Each slot shows one of eight 16 KB RAM banks, or, for the lowest slot, one of four ROM images. Software sets the mapping by writing to two I/O locations, a primary paging register and a secondary paging register. Neither register can be read back.

In normal mode the lowest slot holds ROM and the two middle slots are fixed to banks 5 and 2. The top slot shows the bank chosen by software. A special mode removes ROM from the map and places one of four all-RAM bank layouts across the slots. Besides the mapping, the block gives the video side a choice between two screen banks. It also drives a disk motor line and a printer strobe line. For the slot the CPU is addressing at the moment, it reports whether the mapped bank is a contended one.

A lock bit in the primary register freezes that register until the next reset. The secondary register stays writable while the lock is set.

Top module: `memPager`

## Requirements
- R1: After reset both registers hold zero and the lock is clear. The map is then: slot 0 ROM 0, slot 1 bank 5, slot 2 bank 2, slot 3 bank 0. shadowScreen, diskMotor and printerStrobe are all 0.
- R2: In normal mode, primary register bits 2:0 select the RAM bank shown in slot 3 (C000h-FFFFh).
- R3: In normal mode, slot 0 is ROM (slot0Rom=1, curIsRom=1 when cpuSlot=0, and its slotBanks field reads 0). Slot 1 is bank 5 and slot 2 is bank 2.
- R4: shadowScreen equals primary register bit 3 (0 = normal screen bank 5, 1 = shadow screen bank 7).
- R5: romSel is {secondary bit 2, primary bit 4}. The secondary bit is the high bit.
- R6: A primary write with bit 5 set takes effect and sets the lock. Every later primary write is ignored until reset. Reset clears the lock.
- R7: Secondary bit 0 set enables special mode, in which no slot is ROM. Secondary bits 2:1 pick the banks for slots 0..3: 00 gives 0,1,2,3; 01 gives 4,5,6,7; 10 gives 4,5,6,3; 11 gives 4,7,6,3.
- R8: diskMotor equals secondary bit 3 and printerStrobe equals secondary bit 4.
- R9: A register is written only when ioWrEn is high and ioAddr equals its exact address: 7FFDh for the primary register, 1FFDh for the secondary register. Any other address, or ioWrEn low, changes nothing.
- R10: curContended is 1 exactly when the slot selected by cpuSlot maps a RAM bank numbered 4 to 7. A ROM slot is never contended.
- R11: Secondary register writes take effect whether or not the lock is set.
- R12: Writes take effect on the rising clock edge that samples them. The outputs show the new mapping from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | CPU I/O write cycle |
| ioAddr | input | 16 | CPU I/O address |
| ioData | input | 6 | Low six bits of the CPU data bus |
| cpuSlot | input | 2 | Top two bits of the current CPU memory address |
| slotBanks | output | 12 | Bank of slot n on bits 3n+2:3n |
| slot0Rom | output | 1 | Slot 0 shows ROM |
| romSel | output | 2 | Selected ROM image |
| shadowScreen | output | 1 | Video reads the shadow screen bank |
| diskMotor | output | 1 | Disk motor on |
| printerStrobe | output | 1 | Printer strobe level |
| pagingLocked | output | 1 | Primary register frozen |
| curBank | output | 3 | Bank mapped at cpuSlot |
| curIsRom | output | 1 | cpuSlot maps ROM |
| curContended | output | 1 | cpuSlot maps a contended bank |

## Verification
The assertions assume that ioAddr and ioWrEn are stable around the clock edge and that reset is held for at least one edge. They also assume that only one address can match at a time. The two register addresses differ, so a single write can never strobe both registers. The stimulus changes inputs only on falling edges and holds each write for exactly one rising edge. It sweeps every primary value with the lock bit clear and every secondary value. Writes to the two registers are interleaved with writes to neighbouring addresses and with disabled writes. The lock is set only in a dedicated phase that ends with a reset.

// File: rtl/memPagerPkg.sv
package memPagerPkg;
  localparam int BANK_W = 3;
  localparam int SLOTS  = 4;
  localparam int PRI_W  = 6;
  localparam int SEC_W  = 5;
  // primary register field positions
  localparam int P_LOCK   = 5;
  localparam int P_ROMLO  = 4;
  localparam int P_SCREEN = 3;
  // secondary register field positions
  localparam int S_SPECIAL = 0;
  localparam int S_ROMHI   = 2;
  localparam int S_MOTOR   = 3;
  localparam int S_STROBE  = 4;

  typedef struct packed {
    logic wrPri;
    logic wrSec;
  } pagerStrobes_t;
endpackage

// File: rtl/pagerCtrl.sv
module pagerCtrl
  import memPagerPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 16'h7FFD,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 16'h1FFD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              locked,
  output pagerStrobes_t     strobes
);
  logic hitPri, hitSec;

  always_comb begin
    hitPri = ioWrEn && (ioAddr == PRI_ADDR);
    hitSec = ioWrEn && (ioAddr == SEC_ADDR);
    strobes.wrPri = hitPri && !locked;
    strobes.wrSec = hitSec;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrPri, strobes.wrSec})); // R9
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ioWrEn |-> !(strobes.wrPri || strobes.wrSec)); // R9
endmodule

// File: rtl/pagerPath.sv
module pagerPath
  import memPagerPkg::*;
#(
  parameter int DATA_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pagerStrobes_t           strobes,
  input  logic [DATA_W-1:0]       ioData,
  input  logic [1:0]              cpuSlot,
  output logic [SLOTS*BANK_W-1:0] slotBanks,
  output logic                    slot0Rom,
  output logic [1:0]              romSel,
  output logic                    shadowScreen,
  output logic                    diskMotor,
  output logic                    printerStrobe,
  output logic                    locked,
  output logic [BANK_W-1:0]       curBank,
  output logic                    curIsRom,
  output logic                    curContended
);
  logic [PRI_W-1:0] priReg;
  logic [SEC_W-1:0] secReg;
  logic             special;
  logic [1:0]       layout;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priReg <= '0;
      secReg <= '0;
    end else begin
      if (strobes.wrPri) priReg <= ioData[PRI_W-1:0];
      if (strobes.wrSec) secReg <= ioData[SEC_W-1:0];
    end
  end

  assign special       = secReg[S_SPECIAL];
  assign layout        = secReg[2:1];
  assign locked        = priReg[P_LOCK];
  assign romSel        = {secReg[S_ROMHI], priReg[P_ROMLO]};
  assign shadowScreen  = priReg[P_SCREEN];
  assign diskMotor     = secReg[S_MOTOR];
  assign printerStrobe = secReg[S_STROBE];
  assign slot0Rom      = !special;

  function automatic logic [BANK_W-1:0] specialBank(input logic [1:0] lay,
                                                    input logic [1:0] s);
    logic [BANK_W-1:0] b;
    b = {1'b0, s};
    case (lay)
      2'd0: b = {1'b0, s};
      2'd1: b = {1'b1, s};
      2'd2: b = (s == 2'd3) ? 3'd3 : {1'b1, s};
      default: b = (s == 2'd3) ? 3'd3 : (s == 2'd1) ? 3'd7 : {1'b1, s};
    endcase
    return b;
  endfunction

  function automatic logic [BANK_W-1:0] normalBank(input logic [1:0] s,
                                                   input logic [BANK_W-1:0] top);
    logic [BANK_W-1:0] b;
    case (s)
      2'd0: b = '0;
      2'd1: b = 3'd5;
      2'd2: b = 3'd2;
      default: b = top;
    endcase
    return b;
  endfunction

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    assign slotBanks[g*BANK_W +: BANK_W] = special
      ? specialBank(layout, 2'(g))
      : normalBank(2'(g), priReg[BANK_W-1:0]);
  end

  always_comb begin
    curBank      = slotBanks[cpuSlot*BANK_W +: BANK_W];
    curIsRom     = slot0Rom && (cpuSlot == 2'd0);
    curContended = !curIsRom && curBank[BANK_W-1];
  end

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(priReg)); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked); // R6
  AST_SEC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrSec |=> $stable(secReg)); // R9
  AST_FIXED_MIDDLE: assert property (@(posedge clk) disable iff (!rstN)
    !special |-> (slotBanks[5:3] == 3'd5 && slotBanks[8:6] == 3'd2)); // R3
  AST_SPECIAL_NO_ROM: assert property (@(posedge clk) disable iff (!rstN)
    special |-> !curIsRom); // R7
  AST_CONTEND_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    curContended |-> (curBank >= 3'd4 && !curIsRom)); // R10
endmodule

// File: rtl/memPager.sv
module memPager
  import memPagerPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 6,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 16'h7FFD,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 16'h1FFD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic [1:0]        cpuSlot,
  output logic [11:0]       slotBanks,
  output logic              slot0Rom,
  output logic [1:0]        romSel,
  output logic              shadowScreen,
  output logic              diskMotor,
  output logic              printerStrobe,
  output logic              pagingLocked,
  output logic [2:0]        curBank,
  output logic              curIsRom,
  output logic              curContended
);
  pagerStrobes_t strobes;

  pagerCtrl #(.ADDR_W(ADDR_W), .PRI_ADDR(PRI_ADDR), .SEC_ADDR(SEC_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr),
    .locked(pagingLocked), .strobes(strobes)
  );

  pagerPath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ioData(ioData),
    .cpuSlot(cpuSlot), .slotBanks(slotBanks), .slot0Rom(slot0Rom),
    .romSel(romSel), .shadowScreen(shadowScreen), .diskMotor(diskMotor),
    .printerStrobe(printerStrobe), .locked(pagingLocked), .curBank(curBank),
    .curIsRom(curIsRom), .curContended(curContended)
  );
endmodule

// File: tb/tb_memPager.sv
module tb_memPager;
  logic        clk = 0;
  logic        rstN = 0;
  logic        ioWrEn = 0;
  logic [15:0] ioAddr = '0;
  logic [5:0]  ioData = '0;
  logic [1:0]  cpuSlot = '0;
  logic [11:0] slotBanks;
  logic        slot0Rom, shadowScreen, diskMotor, printerStrobe, pagingLocked;
  logic [1:0]  romSel;
  logic [2:0]  curBank;
  logic        curIsRom, curContended;

  int nChecks = 0;
  int nFails = 0;
  logic [5:0] mPri = '0;
  logic [4:0] mSec = '0;

  always #2 clk = ~clk;

  memPager dut (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioData(ioData),
    .cpuSlot(cpuSlot), .slotBanks(slotBanks), .slot0Rom(slot0Rom),
    .romSel(romSel), .shadowScreen(shadowScreen), .diskMotor(diskMotor),
    .printerStrobe(printerStrobe), .pagingLocked(pagingLocked),
    .curBank(curBank), .curIsRom(curIsRom), .curContended(curContended)
  );

  task automatic chk(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int expBank(input int s);
    int lay;
    lay = (mSec >> 1) & 3;
    if (mSec[0]) begin
      if (lay == 0) return s;
      if (lay == 1) return 4 + s;
      if (lay == 2) return (s == 3) ? 3 : 4 + s;
      return (s == 3) ? 3 : (s == 1) ? 7 : 4 + s;
    end
    if (s == 0) return 0;
    if (s == 1) return 5;
    if (s == 2) return 2;
    return mPri & 7;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [5:0] d, input logic en);
    @(negedge clk);
    ioWrEn = en; ioAddr = a; ioData = d;
    @(negedge clk);
    ioWrEn = 0; ioAddr = '0; ioData = '0;
    if (en && a == 16'h7FFD && !mPri[5]) mPri = d;
    if (en && a == 16'h1FFD) mSec = d[4:0];
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    mPri = '0;
    mSec = '0;
  endtask

  task automatic checkAll(input string tag);
    int rom, eb;
    for (int s = 0; s < 4; s++) begin
      cpuSlot = 2'(s);
      #1;
      rom = (!mSec[0] && s == 0) ? 1 : 0;
      eb = expBank(s);
      chk({tag, " R2/R3/R7 slotBanks"}, int'(slotBanks[s*3 +: 3]), eb);
      chk({tag, " R3 curBank"}, int'(curBank), eb);
      chk({tag, " R3 curIsRom"}, int'(curIsRom), rom);
      chk({tag, " R10 curContended"}, int'(curContended), (rom == 0 && eb >= 4) ? 1 : 0);
    end
    chk({tag, " R7 slot0Rom"}, int'(slot0Rom), mSec[0] ? 0 : 1);
    chk({tag, " R4 shadowScreen"}, int'(shadowScreen), int'(mPri[3]));
    chk({tag, " R5 romSel"}, int'(romSel), int'({mSec[2], mPri[4]}));
    chk({tag, " R8 diskMotor"}, int'(diskMotor), int'(mSec[3]));
    chk({tag, " R8 printerStrobe"}, int'(printerStrobe), int'(mSec[4]));
    chk({tag, " R6 pagingLocked"}, int'(pagingLocked), int'(mPri[5]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    checkAll("R1 reset");

    // R2 R4 R5 R12: every primary value with lock clear
    for (int p = 0; p < 32; p++) begin
      wr(16'h7FFD, 6'(p), 1'b1);
      checkAll("R2 pri sweep");
    end

    // R7 R8 R5: every secondary value
    for (int s = 0; s < 32; s++) begin
      wr(16'h1FFD, 6'(s), 1'b1);
      checkAll("R7 sec sweep");
    end

    // R9: near-miss addresses and disabled writes
    wr(16'h1FFD, 6'h00, 1'b1);
    wr(16'h7FFD, 6'h13, 1'b1);
    wr(16'h7FFC, 6'h06, 1'b1);
    wr(16'hFFFD, 6'h07, 1'b1);
    wr(16'h7FFD, 6'h0E, 1'b0);
    wr(16'h1FFC, 6'h1F, 1'b1);
    wr(16'h3FFD, 6'h19, 1'b1);
    wr(16'h1FFD, 6'h1B, 1'b0);
    checkAll("R9 decode");

    // R6 R11: lock
    wr(16'h7FFD, 6'h2C, 1'b1);
    checkAll("R6 lock set");
    wr(16'h7FFD, 6'h03, 1'b1);
    wr(16'h7FFD, 6'h11, 1'b1);
    checkAll("R6 locked write");
    wr(16'h1FFD, 6'h1D, 1'b1);
    checkAll("R11 sec under lock");
    wr(16'h1FFD, 6'h08, 1'b1);
    checkAll("R11 sec under lock normal");

    doReset();
    checkAll("R6 reset unlock");
    wr(16'h7FFD, 6'h06, 1'b1);
    checkAll("R6 write after unlock");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule